// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of page translations. It turns virtual page numbers into physical frame numbers for the process that is currently running. Every slot carries the identifier of the process that owns it. A context switch therefore only loads a new value into the active-identifier register, and translations that belong to other processes stay resident until they are replaced or flushed.

A lookup presents a virtual address, a store flag and a user-mode flag. One cycle later the block returns a one-hot outcome: a completed translation with its physical address, a miss, a page fault or an access violation. The outcomes are checked in a fixed order. After a miss, the page-table walker outside the block installs the translation through the fill port. A small group of low-index slots can only be written by operating-system fills, and ordinary fills never evict them. Victims are chosen by a not-most-recently-used policy, and empty slots are always used first.

The control port sets the active process identifier. It also flushes every slot that carries a chosen identifier.

Top module: `tlb_pid_cache`

## Requirements
- R1: Each request produces exactly one response, registered on the next clock edge. The outcome code is one-hot: bit 0 means the access completed, bit 1 miss, bit 2 page fault, bit 3 access violation. With no request pending, `rsp_valid` is 0.
- R2: A completed access returns a physical address made of the entry's frame number above the 12 unchanged page-offset bits of the request.
- R3: A slot matches only when both its page tag and its process identifier equal the request's page and the active identifier register. Rewriting that register leaves all slots intact, so restoring an old identifier hits again without any refill.
- R4: The checks run in a fixed order. No matching slot gives a miss. A matching slot whose present bit is 0 gives a page fault, even if the access would also break protection.
- R5: A present entry gives an access violation in three cases: a store to an entry without write permission, a load from an entry without read permission, or a user-mode access to a supervisor-only entry. Any other access completes.
- R6: Only a completed store sets the dirty bit of the matching entry. A fill clears it. `rsp_dirty` reports the entry's dirty bit after a completed access, and a store that is refused leaves the bit clear.
- R7: A flush command invalidates exactly the slots that carry the given process identifier. Slots of other processes keep translating.
- R8: A fill uses the lowest-index empty slot of its region first. When the region has no empty slot, the fill takes the lowest-index slot that is not the most recently used one. A completed access or a fill makes its slot the most recently used.
- R9: Slots 0 to RSV-1 are written only by fills flagged as operating-system fills. Ordinary fills never evict them.
- R10: A fill whose page and identifier equal those of a resident slot overwrites that slot instead of allocating a second copy. Hence at most one slot ever matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_code | output | 4 | One-hot outcome: hit, miss, fault, violation |
| rsp_paddr | output | PFN_W+OFF_W | Physical address for a completed access, else 0 |
| rsp_dirty | output | 1 | Dirty bit of the entry after a completed access |
| fill_valid | input | 1 | Install a translation |
| fill_os | input | 1 | Fill targets the reserved operating-system slots |
| fill_vpn | input | VA_W-OFF_W | Virtual page number to install |
| fill_pid | input | PID_W | Owning process identifier |
| fill_pfn | input | PFN_W | Physical frame number |
| fill_present | input | 1 | Page resident in memory |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_sup | input | 1 | Supervisor-only page |
| pid_we | input | 1 | Load the active process identifier |
| pid_wdata | input | PID_W | New active process identifier |
| flush_valid | input | 1 | Flush the slots of one process |
| flush_pid | input | PID_W | Identifier whose slots are flushed |

## Verification
Every lookup result is due one clock edge after the request is sampled. The bench raises the strobe just after a falling edge, lets exactly one rising edge pass, and reads the outcome, address and dirty flag at the next falling edge. Fills, identifier writes and flushes take effect at the single rising edge that samples them. Each of these is followed by at least one idle falling edge before the next lookup, so every check sees state that is fully settled. Replacement order is observed only at the ports, by finding out which earlier translations now miss.

// File: rtl/tlb_pid_pkg.sv
`timescale 1ns/1ps
package tlb_pid_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic sup;
  } prot_t;

  typedef enum logic [3:0] {
    OUT_NONE  = 4'b0000,
    OUT_HIT   = 4'b0001,
    OUT_MISS  = 4'b0010,
    OUT_FAULT = 4'b0100,
    OUT_VIOL  = 4'b1000
  } outcome_e;

endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic [N-1:0]     used,
  input  logic [VPN_W-1:0] e_vpn [N],
  input  logic [PID_W-1:0] e_pid [N],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic [N-1:0]     hit
);

  // One comparator per slot: page tag and owner must both agree.
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign hit[gi] = used[gi] && (e_vpn[gi] == key_vpn) && (e_pid[gi] == key_pid);
  end

endmodule

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store
  import tlb_pid_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 28,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_present,
  input  prot_t            wr_prot,
  input  logic             set_dirty,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             flush_en,
  input  logic [PID_W-1:0] flush_pid,
  output logic [N-1:0]     e_used,
  output logic [N-1:0]     e_dirty,
  output logic [N-1:0]     e_present,
  output logic [VPN_W-1:0] e_vpn [N],
  output logic [PID_W-1:0] e_pid [N],
  output logic [PFN_W-1:0] e_pfn [N],
  output prot_t            e_prot [N]
);

  logic [N-1:0] used_q, used_d;
  logic [N-1:0] dirty_q, dirty_d;
  logic [N-1:0] load_en;

  // Next state of the control bits. Later lines win: lookup, then flush, then fill.
  always_comb begin
    used_d  = used_q;
    dirty_d = dirty_q;
    if (set_dirty) dirty_d[set_idx] = 1'b1;
    if (flush_en) begin
      for (int i = 0; i < N; i++) begin
        if (e_pid[i] == flush_pid) used_d[i] = 1'b0;
      end
    end
    if (wr_en) begin
      used_d[wr_idx]  = 1'b1;
      dirty_d[wr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= '0;
      dirty_q <= '0;
    end else begin
      used_q  <= used_d;
      dirty_q <= dirty_d;
    end
  end

  // Payload registers: no reset, qualified by the used bit.
  for (genvar gi = 0; gi < N; gi++) begin : g_slot
    logic [VPN_W-1:0] vpn_q;
    logic [PID_W-1:0] pid_q;
    logic [PFN_W-1:0] pfn_q;
    logic             present_q;
    prot_t            prot_q;

    assign load_en[gi] = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (load_en[gi]) begin
        vpn_q     <= wr_vpn;
        pid_q     <= wr_pid;
        pfn_q     <= wr_pfn;
        present_q <= wr_present;
        prot_q    <= wr_prot;
      end
    end

    assign e_vpn[gi]     = vpn_q;
    assign e_pid[gi]     = pid_q;
    assign e_pfn[gi]     = pfn_q;
    assign e_present[gi] = present_q;
    assign e_prot[gi]    = prot_q;
  end

  assign e_used  = used_q;
  assign e_dirty = dirty_q;

  // A fill never leaves the slot empty, whatever else happens that cycle.
  AST_FILL_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> used_q[$past(wr_idx)]) else $error("fill slot empty"); // R8

endmodule

// File: rtl/tlb_nmru.sv
`timescale 1ns/1ps
module tlb_nmru #(
  parameter int N   = 16,
  parameter int RSV = 2,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic             fill_os,
  input  logic [N-1:0]     used,
  input  logic [N-1:0]     dup,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic             fill_we,
  output logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] mru_idx
);

  logic [IDX_W-1:0] mru_q, mru_d;
  logic [N-1:0] rsv_mask, in_reg, empty_v, cand_v, mru_oh;
  logic         dup_any, dup_rsv;

  function automatic logic [IDX_W-1:0] first_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar gi = 0; gi < N; gi++) begin : g_reg
    assign rsv_mask[gi] = (gi < RSV);
    assign mru_oh[gi]   = (mru_q == IDX_W'(gi));
  end

  assign in_reg  = fill_os ? rsv_mask : ~rsv_mask;
  assign empty_v = in_reg & ~used;
  assign cand_v  = in_reg & ~mru_oh;
  assign dup_any = |dup;
  assign dup_rsv = |(dup & rsv_mask);

  always_comb begin
    // An ordinary fill that duplicates a protected slot is dropped.
    fill_we = fill_valid && !(dup_rsv && !fill_os);
    if (dup_any)       fill_idx = first_set(dup);
    else if (|empty_v) fill_idx = first_set(empty_v);
    else if (|cand_v)  fill_idx = first_set(cand_v);
    else               fill_idx = first_set(in_reg);
  end

  always_comb begin
    mru_d = mru_q;
    if (fill_we)       mru_d = fill_idx;
    else if (touch_en) mru_d = touch_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mru_q <= '0;
    else        mru_q <= mru_d;
  end

  assign mru_idx = mru_q;

  AST_RSV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !fill_os) |-> (int'(fill_idx) >= RSV)) else $error("reserved slot taken"); // R9

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !dup_any && (|empty_v)) |-> !used[fill_idx]) else $error("valid slot evicted while empty exists"); // R8

  AST_NOT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !dup_any && !(|empty_v) && (fill_os ? (RSV > 1) : ((N - RSV) > 1)))
      |-> (fill_idx != mru_q)) else $error("most recent slot evicted"); // R8

endmodule

// File: rtl/tlb_pid_cache.sv
`timescale 1ns/1ps
module tlb_pid_cache
  import tlb_pid_pkg::*;
#(
  parameter int N     = 16,
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PFN_W = 28,
  parameter int PID_W = 8,
  parameter int RSV   = 2,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PFN_W + OFF_W,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [3:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_dirty,
  input  logic             fill_valid,
  input  logic             fill_os,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_present,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             fill_sup,
  input  logic             pid_we,
  input  logic [PID_W-1:0] pid_wdata,
  input  logic             flush_valid,
  input  logic [PID_W-1:0] flush_pid
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // Active process identifier.
  logic [PID_W-1:0] pid_q, pid_d;
  always_comb pid_d = pid_we ? pid_wdata : pid_q;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) pid_q <= '0;
    else          pid_q <= pid_d;
  end

  // Entry storage.
  logic [N-1:0]     e_used, e_dirty, e_present;
  logic [VPN_W-1:0] e_vpn [N];
  logic [PID_W-1:0] e_pid [N];
  logic [PFN_W-1:0] e_pfn [N];
  prot_t            e_prot [N];

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, mru_idx;
  logic             set_dirty, done;
  logic [IDX_W-1:0] lk_idx;
  prot_t            fill_prot;

  assign fill_prot = '{rd: fill_rd, wr: fill_wr, sup: fill_sup};

  tlb_store #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_vpn     (fill_vpn),
    .wr_pid     (fill_pid),
    .wr_pfn     (fill_pfn),
    .wr_present (fill_present),
    .wr_prot    (fill_prot),
    .set_dirty  (set_dirty),
    .set_idx    (lk_idx),
    .flush_en   (flush_valid),
    .flush_pid  (flush_pid),
    .e_used     (e_used),
    .e_dirty    (e_dirty),
    .e_present  (e_present),
    .e_vpn      (e_vpn),
    .e_pid      (e_pid),
    .e_pfn      (e_pfn),
    .e_prot     (e_prot)
  );

  // Lookup and duplicate-detection comparators.
  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic [N-1:0]     lk_hit, fl_dup;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
    .used    (e_used),
    .e_vpn   (e_vpn),
    .e_pid   (e_pid),
    .key_vpn (req_vpn),
    .key_pid (pid_q),
    .hit     (lk_hit)
  );

  tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_match (
    .used    (e_used),
    .e_vpn   (e_vpn),
    .e_pid   (e_pid),
    .key_vpn (fill_vpn),
    .key_pid (fill_pid),
    .hit     (fl_dup)
  );

  tlb_nmru #(.N(N), .RSV(RSV)) u_nmru (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .fill_valid (fill_valid),
    .fill_os    (fill_os),
    .used       (e_used),
    .dup        (fl_dup),
    .touch_en   (done),
    .touch_idx  (lk_idx),
    .fill_we    (wr_en),
    .fill_idx   (wr_idx),
    .mru_idx    (mru_idx)
  );

  // Ordered decision: tag, present, protection.
  logic      lk_any, viol;
  prot_t     sel_prot;
  outcome_e  outcome;

  always_comb begin
    lk_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_hit[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_any   = |lk_hit;
  assign sel_prot = e_prot[lk_idx];
  assign viol     = (req_store ? !sel_prot.wr : !sel_prot.rd) || (req_user && sel_prot.sup);

  always_comb begin
    if (!lk_any)                 outcome = OUT_MISS;
    else if (!e_present[lk_idx]) outcome = OUT_FAULT;
    else if (viol)               outcome = OUT_VIOL;
    else                         outcome = OUT_HIT;
  end

  assign done      = req_valid && (outcome == OUT_HIT);
  assign set_dirty = done && req_store;

  // Response register.
  logic            rsp_valid_q, rsp_valid_d;
  outcome_e        rsp_code_q, rsp_code_d;
  logic [PA_W-1:0] rsp_paddr_q, rsp_paddr_d;
  logic            rsp_dirty_q, rsp_dirty_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_code_d  = req_valid ? outcome : OUT_NONE;
    rsp_paddr_d = done ? {e_pfn[lk_idx], req_off} : '0;
    rsp_dirty_d = done && (e_dirty[lk_idx] || req_store);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= OUT_NONE;
      rsp_paddr_q <= '0;
      rsp_dirty_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_code_q  <= rsp_code_d;
      rsp_paddr_q <= rsp_paddr_d;
      rsp_dirty_q <= rsp_dirty_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_paddr = rsp_paddr_q;
  assign rsp_dirty = rsp_dirty_q;

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_valid |=> rsp_valid) else $error("response missing"); // R1

  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n_i)
    !req_valid |=> !rsp_valid) else $error("spurious response"); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> ($countones(rsp_code) == 1)) else $error("outcome not one-hot"); // R1

  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(lk_hit)) else $error("duplicate translation"); // R10

  AST_STORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n_i)
    (req_valid && req_store) |=> ((rsp_code == OUT_HIT) ? rsp_dirty : !rsp_dirty)) else $error("dirty mismatch"); // R6

  AST_MRU_TRACKS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (done && !wr_en) |=> (mru_idx == $past(lk_idx))) else $error("recency not updated"); // R8

endmodule

// File: tb/tlb_pid_cache_bench.sv
`timescale 1ns/1ps
module tlb_pid_cache_bench;

  localparam logic [3:0] C_HIT = 4'b0001, C_MISS = 4'b0010, C_FAULT = 4'b0100, C_VIOL = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_user;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_dirty;
  logic [3:0]  rsp_code;
  logic [39:0] rsp_paddr;
  logic        fill_valid, fill_os, fill_present, fill_rd, fill_wr, fill_sup;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_pid, pid_wdata, flush_pid;
  logic [27:0] fill_pfn;
  logic        pid_we, flush_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tlb_pid_cache u_tlb_pid_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_store(req_store), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_dirty(rsp_dirty),
    .fill_valid(fill_valid), .fill_os(fill_os), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_pfn(fill_pfn), .fill_present(fill_present), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .fill_sup(fill_sup), .pid_we(pid_we), .pid_wdata(pid_wdata),
    .flush_valid(flush_valid), .flush_pid(flush_pid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic st, input logic usr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_code(input string tag, input logic [31:0] va, input logic st,
                             input logic usr, input logic [3:0] code);
    lookup(va, st, usr);
    check(tag, {60'd0, rsp_code}, {60'd0, code});
  endtask

  task automatic fill(input logic os, input logic [19:0] vpn, input logic [7:0] pid,
                      input logic [27:0] pfn, input logic pr, input logic rd,
                      input logic wr, input logic sup);
    @(negedge clk);
    fill_valid = 1'b1; fill_os = os; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn;
    fill_present = pr; fill_rd = rd; fill_wr = wr; fill_sup = sup;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic set_pid(input logic [7:0] p);
    @(negedge clk); pid_we = 1'b1; pid_wdata = p;
    @(negedge clk); pid_we = 1'b0;
  endtask

  task automatic flush(input logic [7:0] p);
    @(negedge clk); flush_valid = 1'b1; flush_pid = p;
    @(negedge clk); flush_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 reset rsp_code", {60'd0, rsp_code}, 64'd0);
    lookup(32'h1234_5678, 1'b0, 1'b0);
    check("R1 rsp_valid one cycle later", {63'd0, rsp_valid}, 64'd1);
    check("R1 empty lookup misses", {60'd0, rsp_code}, {60'd0, C_MISS});
    @(negedge clk);
    check("R1 no request no response", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_translate;
    set_pid(8'd1);
    fill(1'b0, 20'h12345, 8'd1, 28'hABCDEF1, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R2 hit code", 32'h1234_5678, 1'b0, 1'b1, C_HIT);
    check("R2 physical address", {24'd0, rsp_paddr}, {24'd0, 28'hABCDEF1, 12'h678});
    expect_code("R2 other offset", 32'h1234_5FFF, 1'b0, 1'b0, C_HIT);
    check("R2 offset passes", {24'd0, rsp_paddr}, {24'd0, 28'hABCDEF1, 12'hFFF});
  endtask

  task automatic t_context;
    set_pid(8'd2);
    expect_code("R3 other process misses", 32'h1234_5000, 1'b0, 1'b0, C_MISS);
    fill(1'b0, 20'h12345, 8'd2, 28'h0000111, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R3 second process hits", 32'h1234_5004, 1'b0, 1'b0, C_HIT);
    check("R3 second process frame", {24'd0, rsp_paddr}, {24'd0, 28'h0000111, 12'h004});
    set_pid(8'd1);
    expect_code("R3 restored process hits", 32'h1234_5004, 1'b0, 1'b0, C_HIT);
    check("R3 restored frame", {24'd0, rsp_paddr}, {24'd0, 28'hABCDEF1, 12'h004});
  endtask

  task automatic t_order;
    fill(1'b0, 20'h00200, 8'd1, 28'h0000200, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_code("R4 fault wins over violation", 32'h0020_0010, 1'b1, 1'b1, C_FAULT);
    check("R4 fault no address", {24'd0, rsp_paddr}, 64'd0);
    expect_code("R4 unknown page misses", 32'h0099_9000, 1'b1, 1'b1, C_MISS);
  endtask

  task automatic t_protect;
    fill(1'b0, 20'h00300, 8'd1, 28'h0000300, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_code("R5 store to read-only", 32'h0030_0000, 1'b1, 1'b0, C_VIOL);
    expect_code("R5 load from read-only", 32'h0030_0000, 1'b0, 1'b1, C_HIT);
    fill(1'b0, 20'h00301, 8'd1, 28'h0000301, 1'b1, 1'b1, 1'b1, 1'b1);
    expect_code("R5 user on supervisor page", 32'h0030_1000, 1'b0, 1'b1, C_VIOL);
    expect_code("R5 supervisor on supervisor page", 32'h0030_1000, 1'b0, 1'b0, C_HIT);
    fill(1'b0, 20'h00302, 8'd1, 28'h0000302, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_code("R5 load without read", 32'h0030_2000, 1'b0, 1'b1, C_VIOL);
    expect_code("R5 store with write", 32'h0030_2000, 1'b1, 1'b1, C_HIT);
  endtask

  task automatic t_dirty;
    fill(1'b0, 20'h00400, 8'd1, 28'h0000400, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R6 clean load", 32'h0040_0000, 1'b0, 1'b0, C_HIT);
    check("R6 fresh entry clean", {63'd0, rsp_dirty}, 64'd0);
    expect_code("R6 refused store", 32'h0030_0000, 1'b1, 1'b0, C_VIOL);
    expect_code("R6 after refused store", 32'h0030_0000, 1'b0, 1'b0, C_HIT);
    check("R6 refused store left clean", {63'd0, rsp_dirty}, 64'd0);
    expect_code("R6 store completes", 32'h0040_0008, 1'b1, 1'b0, C_HIT);
    check("R6 store reports dirty", {63'd0, rsp_dirty}, 64'd1);
    expect_code("R6 later load", 32'h0040_0008, 1'b0, 1'b0, C_HIT);
    check("R6 dirty kept", {63'd0, rsp_dirty}, 64'd1);
  endtask

  task automatic t_flush;
    flush(8'd1);
    expect_code("R7 flushed process misses", 32'h1234_5000, 1'b0, 1'b0, C_MISS);
    expect_code("R7 flushed entry misses", 32'h0040_0000, 1'b0, 1'b0, C_MISS);
    set_pid(8'd2);
    expect_code("R7 other process survives", 32'h1234_5000, 1'b0, 1'b0, C_HIT);
    flush(8'd2);
    expect_code("R7 second flush", 32'h1234_5000, 1'b0, 1'b0, C_MISS);
  endtask

  task automatic t_nmru;
    set_pid(8'd3);
    for (int i = 0; i < 14; i++)
      fill(1'b0, 20'h01000 + 20'(i), 8'd3, 28'h1000 + 28'(i), 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R8 oldest still present", 32'h0100_0000, 1'b0, 1'b0, C_HIT);
    fill(1'b0, 20'h02000, 8'd3, 28'h2000, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R8 lowest non-recent evicted", 32'h0100_1000, 1'b0, 1'b0, C_MISS);
    expect_code("R8 recent slot spared", 32'h0100_0000, 1'b0, 1'b0, C_HIT);
    expect_code("R8 new entry present", 32'h0200_0000, 1'b0, 1'b0, C_HIT);
    expect_code("R8 others untouched", 32'h0100_2000, 1'b0, 1'b0, C_HIT);
  endtask

  task automatic t_reserved;
    fill(1'b1, 20'h0F000, 8'd3, 28'hF000, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++)
      fill(1'b0, 20'h03000 + 20'(i), 8'd3, 28'h3000 + 28'(i), 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R9 reserved entry survives", 32'h0F00_0000, 1'b0, 1'b0, C_HIT);
    check("R9 reserved frame", {24'd0, rsp_paddr}, {24'd0, 28'hF000, 12'h000});
    expect_code("R9 ordinary fills cycled", 32'h0100_0000, 1'b0, 1'b0, C_MISS);
  endtask

  task automatic t_dup;
    flush(8'd3);
    set_pid(8'd4);
    fill(1'b0, 20'h05000, 8'd4, 28'h0000001, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 13; i++)
      fill(1'b0, 20'h05100 + 20'(i), 8'd4, 28'h5100 + 28'(i), 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R10 original present", 32'h0500_0000, 1'b0, 1'b0, C_HIT);
    fill(1'b0, 20'h05000, 8'd4, 28'h0000002, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_code("R10 refill hits", 32'h0500_0010, 1'b0, 1'b0, C_HIT);
    check("R10 refill overwrote frame", {24'd0, rsp_paddr}, {24'd0, 28'h0000002, 12'h010});
    for (int i = 0; i < 13; i++)
      expect_code("R10 no entry displaced", {20'h05100 + 20'(i), 12'h000}, 1'b0, 1'b0, C_HIT);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = '0; req_store = 0; req_user = 0;
    fill_valid = 0; fill_os = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0;
    fill_present = 0; fill_rd = 0; fill_wr = 0; fill_sup = 0;
    pid_we = 0; pid_wdata = '0; flush_valid = 0; flush_pid = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_translate();
    t_context();
    t_order();
    t_protect();
    t_dirty();
    t_flush();
    t_nmru();
    t_reserved();
    t_dup();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule